// File: doc/BRIEF.md
# Card Clock Selector

This block turns a fast input clock into the clock sent to a smart card. A two-bit ratio select picks one of four outputs: held low, a copy of the input clock, the input divided by two, or the input divided by four. The divided outputs come straight from flip-flops clocked on the rising input edge, so their duty cycle is exactly 50% whatever the duty cycle of the input. A pass-through copy is made by gating the input with an enable that only changes while the input is low. Input clocks up to 40 MHz are expected. The system is responsible for choosing a ratio that keeps the card clock at or below 20 MHz.

The card clock is forced low whenever the card-supply-ready flag is low, which covers both the supply start-up period and the supply being off. A new ratio is applied only at a point where the output is low, so the card never sees a truncated high pulse because of a ratio change. The block also holds a slow/fast edge-rate flag for the card clock pad driver. A configuration write updates this flag: one command code selects fast edges and another selects slow edges.

All control inputs are synchronous to `clk_in` and must be stable at both of its edges.

Top module: `cclk_selector`

## Requirements
- R1: While `rst_n` is low, `card_clk` is low and `slope_fast` is 0 (slow edges), whatever the other inputs are. Asserting reset takes effect without waiting for a clock edge. Reset release is synchronized over two rising edges of `clk_in`.
- R2: With `supply_ok` high and `ratio_sel` = 2'b00, `card_clk` stays low.
- R3: With `ratio_sel` = 2'b01, `card_clk` follows `clk_in`. It is high during every high phase and low during every low phase of the input, and it only ever passes whole phases.
- R4: With `ratio_sel` = 2'b10, `card_clk` rises on a rising edge of `clk_in`. It stays high for exactly one input period and then low for exactly one input period.
- R5: With `ratio_sel` = 2'b11, `card_clk` stays high for exactly two input periods and then low for exactly two input periods.
- R6: Once `supply_ok` falls, `card_clk` is low from the second rising edge of `clk_in` onward, for any `ratio_sel`, until `supply_ok` returns high.
- R7: When `ratio_sel` changes, the high pulse in progress runs to its full length before the new ratio is applied. That length is one input half-period for pass-through, two half-periods for divide-by-2 and four half-periods for divide-by-4. No shorter high pulse appears, except when the supply is lost or reset is asserted.
- R8: A cycle with `cfg_wr` high and `cfg_data` = 5'b00101 sets `slope_fast` to 1 from the next rising edge. A cycle with `cfg_wr` high and `cfg_data` = 5'b00100 clears it to 0. Any other code, or `cfg_wr` low, leaves `slope_fast` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock, the source of the card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Ratio select: 00 low, 01 pass-through, 10 divide by 2, 11 divide by 4 |
| supply_ok | input | 1 | Card supply is up and stable |
| cfg_wr | input | 1 | Configuration command strobe |
| cfg_data | input | 5 | Configuration command code |
| card_clk | output | 1 | Clock to the card |
| slope_fast | output | 1 | Edge-rate control for the pad driver: 1 fast, 0 slow |

## Verification
The hardest cases to reach are the ones where an input changes in the middle of a card clock high phase. Examples are a ratio change during the first half of a divide-by-4 high pulse, and supply loss while a pulse is high. To create them, the stimulus samples `card_clk` every half period and waits until it sees a fresh rising sample, then changes `ratio_sel` or `supply_ok` immediately. A background monitor measures every high run in half-period units and flags any run whose length does not fit the active ratio.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_PASS = 2'b01,
    MODE_DIV2 = 2'b10,
    MODE_DIV4 = 2'b11
  } ccs_mode_e;

  localparam int unsigned HALF_DIV2 = 1;
  localparam int unsigned HALF_DIV4 = 2;
  localparam int unsigned CNT_W     = (HALF_DIV4 > 1) ? $clog2(HALF_DIV4) : 1;

  function automatic logic [CNT_W-1:0] half_term(input ccs_mode_e m);
    if (m == MODE_DIV4) return CNT_W'(HALF_DIV4 - 1);
    else                return CNT_W'(HALF_DIV2 - 1);
  endfunction

endpackage

// File: rtl/ccs_rst_sync.sv
module ccs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 1'b0;
        else        sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sn = sh_q[STAGES-1];

endmodule

// File: rtl/ccs_slope_reg.sv
module ccs_slope_reg #(
  parameter int unsigned     CFG_W     = 5,
  parameter logic [CFG_W-1:0] SLOW_CODE = CFG_W'(4),
  parameter logic [CFG_W-1:0] FAST_CODE = CFG_W'(5)
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic             slope_fast
);

  logic fast_q, fast_d;
  logic hit_fast, hit_slow;

  assign hit_fast = cfg_wr && (cfg_data == FAST_CODE);
  assign hit_slow = cfg_wr && (cfg_data == SLOW_CODE);

  always_comb begin
    fast_d = fast_q;
    if (hit_fast)      fast_d = 1'b1;
    else if (hit_slow) fast_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) fast_q <= 1'b0;
    else         fast_q <= fast_d;
  end

  assign slope_fast = fast_q;

  // R8: fast code takes effect on the next edge
  p_fast_code_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_wr && cfg_data == FAST_CODE) |=> slope_fast);

  // R8: slow code takes effect on the next edge
  p_slow_code_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_wr && cfg_data == SLOW_CODE) |=> !slope_fast);

  // R8: no strobe, no change
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !cfg_wr |=> $stable(slope_fast));

endmodule

// File: rtl/ccs_div_core.sv
module ccs_div_core
  import ccs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sn,
  input  ccs_mode_e req_mode,
  input  logic      supply_ok,
  input  logic      pass_en,
  output ccs_mode_e act_mode,
  output logic      div_q
);

  ccs_mode_e        act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic [CNT_W-1:0] term;

  assign term = half_term(act_q);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    out_d = out_q;
    if (!supply_ok) begin
      act_d = MODE_STOP;
      cnt_d = '0;
      out_d = 1'b0;
    end else begin
      unique case (act_q)
        MODE_STOP: begin
          cnt_d = '0;
          out_d = 1'b0;
          if (req_mode != MODE_STOP && !pass_en) act_d = req_mode;
        end
        MODE_PASS: begin
          if (req_mode != MODE_PASS && !pass_en) act_d = MODE_STOP;
        end
        default: begin
          if (cnt_q == term) begin
            cnt_d = '0;
            if (out_q)                     out_d = 1'b0;
            else if (req_mode != act_q)    act_d = MODE_STOP;
            else                           out_d = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      act_q <= MODE_STOP;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign act_mode = act_q;
  assign div_q    = out_q;

  // R7: mode handover only while both output sources are low
  p_switch_low_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (supply_ok && act_d != act_q) |-> (!out_q && !pass_en));

  // R5: a divide-by-4 high phase lasts at least two input periods
  p_div4_hold_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (act_q == MODE_DIV4 && $rose(out_q) && supply_ok) |=> out_q);

  // R4: a divide-by-2 high phase lasts exactly one input period
  p_div2_drop_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (act_q == MODE_DIV2 && out_q && supply_ok) |=> !out_q);

endmodule

// File: rtl/ccs_pass_gate.sv
module ccs_pass_gate
  import ccs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sn,
  input  ccs_mode_e act_mode,
  input  ccs_mode_e req_mode,
  output logic      pass_en,
  output logic      gclk
);

  logic en_q, en_d;

  assign en_d = (act_mode == MODE_PASS) && (req_mode == MODE_PASS);

  always_ff @(negedge clk or negedge rst_sn) begin
    if (!rst_sn) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign pass_en = en_q;
  assign gclk    = clk & en_q;

endmodule

// File: rtl/cclk_selector.sv
module cclk_selector
  import ccs_pkg::*;
#(
  parameter int unsigned      CFG_W      = 5,
  parameter logic [CFG_W-1:0] SLOW_CODE  = CFG_W'(4),
  parameter logic [CFG_W-1:0] FAST_CODE  = CFG_W'(5),
  parameter int unsigned      RST_STAGES = 2
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [1:0]       ratio_sel,
  input  logic             supply_ok,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic             card_clk,
  output logic             slope_fast
);

  logic      rst_sn;
  ccs_mode_e req_mode;
  ccs_mode_e act_mode;
  logic      pass_en;
  logic      gclk;
  logic      div_q;

  assign req_mode = supply_ok ? ccs_mode_e'(ratio_sel) : MODE_STOP;

  ccs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk_in),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  ccs_div_core u_div (
    .clk       (clk_in),
    .rst_sn    (rst_sn),
    .req_mode  (req_mode),
    .supply_ok (supply_ok),
    .pass_en   (pass_en),
    .act_mode  (act_mode),
    .div_q     (div_q)
  );

  ccs_pass_gate u_gate (
    .clk      (clk_in),
    .rst_sn   (rst_sn),
    .act_mode (act_mode),
    .req_mode (req_mode),
    .pass_en  (pass_en),
    .gclk     (gclk)
  );

  ccs_slope_reg #(
    .CFG_W     (CFG_W),
    .SLOW_CODE (SLOW_CODE),
    .FAST_CODE (FAST_CODE)
  ) u_slope (
    .clk        (clk_in),
    .rst_sn     (rst_sn),
    .cfg_wr     (cfg_wr),
    .cfg_data   (cfg_data),
    .slope_fast (slope_fast)
  );

  assign card_clk = gclk | div_q;

  // R3: the pass enable is only open while pass-through is the active mode
  p_gate_mode_r3: assert property (@(posedge clk_in) disable iff (!rst_sn)
    pass_en |-> (act_mode == MODE_PASS));

  // R6: divider output is low after an edge that saw the supply down
  p_supply_div_r6: assert property (@(posedge clk_in) disable iff (!rst_sn)
    !supply_ok |=> !div_q);

  // R6: pass enable is closed once the supply has been down for a full cycle
  p_supply_gate_r6: assert property (@(posedge clk_in) disable iff (!rst_sn)
    (!supply_ok && $past(!supply_ok)) |-> !pass_en);

  // R7: the two output sources are never open together
  p_one_source_r7: assert property (@(posedge clk_in) disable iff (!rst_sn)
    !(pass_en && div_q));

endmodule

// File: tb/tb_cclk_selector.sv
module tb_cclk_selector;

  logic       clk_in = 1'b0;
  logic       rst_n;
  logic [1:0] ratio_sel;
  logic       supply_ok;
  logic       cfg_wr;
  logic [4:0] cfg_data;
  logic       card_clk;
  logic       slope_fast;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_in = ~clk_in;

  cclk_selector dut (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .ratio_sel  (ratio_sel),
    .supply_ok  (supply_ok),
    .cfg_wr     (cfg_wr),
    .cfg_data   (cfg_data),
    .card_clk   (card_clk),
    .slope_fast (slope_fast)
  );

  // vector: {supply_ok, ratio_sel[1:0], expected mode[1:0]}
  localparam int NV = 10;
  localparam logic [4:0] VEC [0:NV-1] = '{
    {1'b1, 2'b00, 2'b00},
    {1'b1, 2'b01, 2'b01},
    {1'b1, 2'b10, 2'b10},
    {1'b1, 2'b11, 2'b11},
    {1'b1, 2'b01, 2'b01},
    {1'b0, 2'b10, 2'b00},
    {1'b1, 2'b11, 2'b11},
    {1'b1, 2'b10, 2'b10},
    {1'b0, 2'b01, 2'b00},
    {1'b1, 2'b00, 2'b00}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic samp(output logic h, output logic l);
    @(posedge clk_in);
    #1 h = card_clk;
    #4 l = card_clk;
  endtask

  // background run-length monitor (R7)
  bit mon_en      = 1'b0;
  bit allow_trunc = 1'b0;
  int run         = 0;

  task automatic half_tick(input logic v);
    if (v) run++;
    else if (run != 0) begin
      if (mon_en && !allow_trunc)
        chk(run == 1 || run == 2 || run == 4, "R7", "high run in half periods", run, 4);
      run = 0;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_in);
      #1 half_tick(card_clk);
      #4 half_tick(card_clk);
    end
  end

  function automatic bit pattern_ok(input logic [1:0] m, input logic [7:0] hv,
                                    input logic [7:0] lv);
    bit ok = 1'b1;
    case (m)
      2'b00: ok = (hv == 8'h00) && (lv == 8'h00);
      2'b01: ok = (hv == 8'hFF) && (lv == 8'h00);
      2'b10: begin
        ok = (hv == lv);
        for (int i = 0; i < 7; i++) if (hv[i] == hv[i+1]) ok = 1'b0;
      end
      default: begin
        ok = (hv == lv);
        for (int i = 0; i < 6; i++) if (hv[i] == hv[i+2]) ok = 1'b0;
      end
    endcase
    return ok;
  endfunction

  task automatic measure(output logic [7:0] hv, output logic [7:0] lv);
    logic h, l;
    for (int i = 0; i < 8; i++) begin
      samp(h, l);
      hv[i] = h;
      lv[i] = l;
    end
  endtask

  task automatic wait_rise(output bit seen);
    logic h, l, prev;
    prev = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      samp(h, l);
      if (!prev && h) begin
        seen = 1'b1;
        break;
      end
      prev = h;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_in);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic       h, l;
    logic [7:0] hv, lv;
    bit         seen;
    string      tag;

    rst_n = 1'b0; ratio_sel = 2'b10; supply_ok = 1'b1;
    cfg_wr = 1'b0; cfg_data = '0;

    // R1: reset state with a running ratio requested
    for (int i = 0; i < 3; i++) begin
      samp(h, l);
      chk(!h && !l, "R1", "card_clk in reset", int'(h | l), 0);
    end
    chk(slope_fast == 1'b0, "R1", "slope_fast in reset", int'(slope_fast), 0);
    ratio_sel = 2'b00;
    rst_n = 1'b1;
    repeat (4) samp(h, l);
    mon_en = 1'b1;

    // table walk: R2..R6 steady behaviour
    for (int v = 0; v < NV; v++) begin
      supply_ok = VEC[v][4];
      ratio_sel = VEC[v][3:2];
      repeat (8) samp(h, l);
      measure(hv, lv);
      if (!VEC[v][4])              tag = "R6";
      else if (VEC[v][1:0] == 2'b00) tag = "R2";
      else if (VEC[v][1:0] == 2'b01) tag = "R3";
      else if (VEC[v][1:0] == 2'b10) tag = "R4";
      else                          tag = "R5";
      chk(pattern_ok(VEC[v][1:0], hv, lv), tag, "pattern high samples", int'(hv), int'(VEC[v][1:0]));
    end

    // R8: slope control codes
    cfg_wr = 1'b1; cfg_data = 5'b00101;
    samp(h, l);
    chk(slope_fast == 1'b1, "R8", "fast code", int'(slope_fast), 1);
    cfg_data = 5'b00011;
    samp(h, l);
    chk(slope_fast == 1'b1, "R8", "other code ignored", int'(slope_fast), 1);
    cfg_wr = 1'b0; cfg_data = 5'b00100;
    samp(h, l);
    chk(slope_fast == 1'b1, "R8", "no strobe ignored", int'(slope_fast), 1);
    cfg_wr = 1'b1;
    samp(h, l);
    chk(slope_fast == 1'b0, "R8", "slow code", int'(slope_fast), 0);
    cfg_data = 5'b00101;
    samp(h, l);
    cfg_wr = 1'b0;
    chk(slope_fast == 1'b1, "R8", "fast code again", int'(slope_fast), 1);

    // R7: ratio change in the first cycle of a divide-by-4 high phase
    supply_ok = 1'b1; ratio_sel = 2'b11;
    repeat (10) samp(h, l);
    wait_rise(seen);
    chk(seen, "R7", "div4 rise seen", int'(seen), 1);
    ratio_sel = 2'b10;
    samp(h, l);
    chk(h && l, "R7", "div4 high kept after change", int'(h & l), 1);
    repeat (10) samp(h, l);
    measure(hv, lv);
    chk(pattern_ok(2'b10, hv, lv), "R7", "div2 after change", int'(hv), 2);

    // R7: pass-through to divide-by-4
    ratio_sel = 2'b01;
    repeat (10) samp(h, l);
    ratio_sel = 2'b11;
    repeat (10) samp(h, l);
    measure(hv, lv);
    chk(pattern_ok(2'b11, hv, lv), "R7", "div4 after pass", int'(hv), 3);

    // R6: supply loss during a divide-by-4 high phase
    wait_rise(seen);
    allow_trunc = 1'b1;
    supply_ok = 1'b0;
    samp(h, l);
    for (int i = 0; i < 6; i++) begin
      samp(h, l);
      chk(!h && !l, "R6", "low after supply loss div4", int'(h | l), 0);
    end
    allow_trunc = 1'b0;

    // R6: supply loss in pass-through
    supply_ok = 1'b1; ratio_sel = 2'b01;
    repeat (8) samp(h, l);
    supply_ok = 1'b0;
    samp(h, l);
    for (int i = 0; i < 6; i++) begin
      samp(h, l);
      chk(!h && !l, "R6", "low after supply loss pass", int'(h | l), 0);
    end

    // R1: asynchronous reset during divide-by-2
    supply_ok = 1'b1; ratio_sel = 2'b10;
    repeat (8) samp(h, l);
    wait_rise(seen);
    @(posedge clk_in);
    allow_trunc = 1'b1;
    #2 rst_n = 1'b0;
    #1;
    chk(card_clk == 1'b0, "R1", "card_clk at reset assertion", int'(card_clk), 0);
    chk(slope_fast == 1'b0, "R1", "slope_fast at reset assertion", int'(slope_fast), 0);
    samp(h, l);
    chk(!h && !l, "R1", "card_clk held in reset", int'(h | l), 0);
    rst_n = 1'b1;
    repeat (8) samp(h, l);
    allow_trunc = 1'b0;
    measure(hv, lv);
    chk(pattern_ok(2'b10, hv, lv), "R4", "div2 after reset release", int'(hv), 2);

    finish_run();
  end

endmodule